// File: doc/BRIEF.md
# Interrupt Source Configuration and Routing

This block keeps the per-source settings of an interrupt controller and turns activity on the raw interrupt lines into raise and withdraw strobes for one or more CPUs. Each source has a vector/priority word and a destination word. Both are written and read back through a small register port. The block handles masking, level versus edge sensing, a read-only activity bit, and two delivery modes. Directed mode sends to every CPU in the destination mask. Distributed mode sends to exactly one CPU and rotates from the CPU served last.

Any event on a source marks it dirty. An event is a pending change, a rising edge on an edge source, or a write to its vector/priority word. A two-state machine then routes one dirty source at a time, lowest index first. `RT_IDLE` claims the lowest dirty source and moves to `RT_ROUTE` (the claim transition). `RT_ROUTE` evaluates that source, registers the strobes and returns to `RT_IDLE` unconditionally (the emit transition). Priority arbitration among the CPUs lies outside this block. Only an acknowledge-clear input reaches back into it, and that input retires edge-triggered sources.

The defaults are 32 sources and 4 CPUs. Sources 0 to 15 are external, 16 to 27 are internal, and 28 to 31 are timer or inter-processor sources.

Top module: `irq_src_router`

## Requirements
- R1: The vector/priority word reads back as: mask at bit 31, activity at bit 30, delivery mode at bit 29, polarity at bit 23, sense at bit 22, priority at bits 19:16, vector at bits 15:0, all other bits zero. A write updates mask, mode, polarity, sense, priority and vector but never the activity bit. The destination word (field select 1) holds one bit per CPU in its low bits.
- R2: After reset every source reads 0x8000_0000 (masked), except internal sources, which read 0x8080_0000. Every destination word reads 1 (CPU 0 only), and no strobe is driven.
- R3: A masked source produces no strobe and leaves its activity bit unchanged. Clearing the mask while the source is pending raises the source.
- R4: A level source (sense bit 1 on an external source) is pending while its line is 1. When pending becomes true, a raise strobe appears carrying the source number, priority and vector, and the activity bit is set. When pending becomes false, a withdraw strobe appears and the activity bit is cleared. The strobe lasts one cycle and is visible after the third rising edge following the line change or the register write.
- R5: An edge source (sense bit 0 on an external source) becomes pending only on a 0-to-1 line transition. A falling line has no effect. The acknowledge-clear input clears the pending state and activity bit of an edge source without a strobe. On a level source it has no effect.
- R6: A source that is neither pending nor active is not routed, so a write to it produces no strobe. A source with a zero destination word emits no strobe, but its activity bit still follows its pending state.
- R7: If the destination word equals only the bit of the CPU served last, that CPU alone is targeted in either mode. Otherwise, in directed mode (mode bit 0), every CPU whose destination bit is set is targeted.
- R8: In distributed mode (mode bit 1), the CPUs are scanned cyclically from the one after the last-served CPU, wrapping at the CPU count. The first CPU with its destination bit set is targeted and becomes the last-served CPU. This applies to withdraws as well as raises. The last-served CPU resets to 0.
- R9: Internal sources are always level-triggered and their sense bit reads 0. Timer and inter-processor sources are always edge-triggered and their sense and polarity bits read 0.
- R10: At most one source is routed per decision, lowest index first, and a single decision never carries raise and withdraw together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_line | input | NUM_SRC | Raw interrupt lines, one per source |
| cfg_wr | input | 1 | Write strobe for the register port |
| cfg_sel | input | SRC_W | Source selected for write and read |
| cfg_field | input | 1 | 0 selects the vector/priority word, 1 the destination word |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the selected word (combinational) |
| ack_clr | input | 1 | Acknowledge-clear strobe for an edge source |
| ack_src | input | SRC_W | Source addressed by ack_clr |
| raise_cpu | output | NUM_CPU | One-cycle raise strobes, one bit per CPU |
| drop_cpu | output | NUM_CPU | One-cycle withdraw strobes, one bit per CPU |
| out_src | output | SRC_W | Source number of the current decision |
| out_prio | output | 4 | Priority of the current decision |
| out_vec | output | 16 | Vector of the current decision |

## Verification
A stuck or stale activity bit is visible in two places. It shows in the read-back word in the very next cycle, and it shows as a missing or duplicated strobe the next time the source line moves. A wrong last-served CPU stays hidden until the second distributed delivery of the same source, so the bench chains three deliveries on one source to expose the rotation and the wrap. A dirty bit that is lost or never cleared shows as a strobe that does not arrive, or as repeated strobes, in the third cycle after the event.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int VP_MASK_BIT  = 31;
    localparam int VP_ACT_BIT   = 30;
    localparam int VP_MODE_BIT  = 29;
    localparam int VP_POL_BIT   = 23;
    localparam int VP_SENSE_BIT = 22;
    localparam int PRIO_LSB     = 16;
    localparam int PRIO_W       = 4;
    localparam int VEC_W        = 16;

    typedef enum logic [0:0] {
        RT_IDLE  = 1'b0,
        RT_ROUTE = 1'b1
    } route_state_e;

    typedef enum logic [1:0] {
        KIND_EXT = 2'd0,
        KIND_INT = 2'd1,
        KIND_SPC = 2'd2
    } src_kind_e;

    function automatic src_kind_e kind_of(input int idx, input int int_first, input int spc_first);
        if (idx >= spc_first) return KIND_SPC;
        if (idx >= int_first) return KIND_INT;
        return KIND_EXT;
    endfunction

endpackage

// File: rtl/irq_src_cfg.sv
module irq_src_cfg
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC   = 32,
    parameter int NUM_CPU   = 4,
    parameter int INT_FIRST = 16,
    parameter int SPC_FIRST = 28,
    localparam int SRC_W    = $clog2(NUM_SRC)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [SRC_W-1:0]           sel,
    input  logic                       sel_dest,
    input  logic [31:0]                wdata,
    output logic [31:0]                rdata,
    input  logic                       act_upd,
    input  logic [SRC_W-1:0]           act_idx,
    input  logic                       act_val,
    input  logic                       ack_en,
    input  logic [SRC_W-1:0]           ack_idx,
    output logic [NUM_SRC-1:0]         mask_o,
    output logic [NUM_SRC-1:0]         act_o,
    output logic [NUM_SRC-1:0]         mode_o,
    output logic [NUM_SRC-1:0]         level_o,
    output logic [NUM_SRC*PRIO_W-1:0]  prio_o,
    output logic [NUM_SRC*VEC_W-1:0]   vec_o,
    output logic [NUM_SRC*NUM_CPU-1:0] dest_o
);

    logic [31:0] vp_word   [NUM_SRC];
    logic [31:0] dest_word [NUM_SRC];
    logic        unused_bits;

    assign unused_bits = &{wdata[VP_ACT_BIT], wdata[28:24], wdata[21:20]};

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        localparam src_kind_e KIND    = kind_of(i, INT_FIRST, SPC_FIRST);
        localparam logic      POL_RST = (KIND == KIND_INT);

        logic               mask_q, act_q, mode_q, pol_q, sense_q, lvl;
        logic [PRIO_W-1:0]  prio_q;
        logic [VEC_W-1:0]   vec_q;
        logic [NUM_CPU-1:0] dest_q;
        logic               hit;

        assign hit = wr_en && (sel == SRC_W'(i));
        assign lvl = (KIND == KIND_INT) ? 1'b1 :
                     (KIND == KIND_SPC) ? 1'b0 : sense_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_q  <= 1'b1;
                act_q   <= 1'b0;
                mode_q  <= 1'b0;
                pol_q   <= POL_RST;
                sense_q <= 1'b0;
                prio_q  <= '0;
                vec_q   <= '0;
                dest_q  <= NUM_CPU'(1);
            end else begin
                if (hit && !sel_dest) begin
                    mask_q  <= wdata[VP_MASK_BIT];
                    mode_q  <= wdata[VP_MODE_BIT];
                    pol_q   <= (KIND == KIND_SPC) ? 1'b0 : wdata[VP_POL_BIT];
                    sense_q <= (KIND == KIND_EXT) ? wdata[VP_SENSE_BIT] : 1'b0;
                    prio_q  <= wdata[PRIO_LSB +: PRIO_W];
                    vec_q   <= wdata[VEC_W-1:0];
                end
                if (hit && sel_dest) begin
                    dest_q <= wdata[NUM_CPU-1:0];
                end
                if (act_upd && (act_idx == SRC_W'(i))) begin
                    act_q <= act_val;
                end
                if (ack_en && (ack_idx == SRC_W'(i)) && !lvl) begin
                    act_q <= 1'b0;
                end
            end
        end

        assign mask_o[i]                     = mask_q;
        assign act_o[i]                      = act_q;
        assign mode_o[i]                     = mode_q;
        assign level_o[i]                    = lvl;
        assign prio_o[i*PRIO_W +: PRIO_W]    = prio_q;
        assign vec_o[i*VEC_W +: VEC_W]       = vec_q;
        assign dest_o[i*NUM_CPU +: NUM_CPU]  = dest_q;
        assign vp_word[i]   = {mask_q, act_q, mode_q, 5'b0, pol_q, sense_q, 2'b0, prio_q, vec_q};
        assign dest_word[i] = {{(32-NUM_CPU){1'b0}}, dest_q};
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            if (sel == SRC_W'(k)) begin
                rdata = sel_dest ? dest_word[k] : vp_word[k];
            end
        end
    end

endmodule

// File: rtl/irq_src_pending.sv
module irq_src_pending #(
    parameter int NUM_SRC = 32,
    localparam int SRC_W  = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] line,
    input  logic [NUM_SRC-1:0] level,
    input  logic               ack_en,
    input  logic [SRC_W-1:0]   ack_idx,
    input  logic               touch_en,
    input  logic [SRC_W-1:0]   touch_idx,
    input  logic               take_en,
    input  logic [SRC_W-1:0]   take_idx,
    output logic [NUM_SRC-1:0] pend_o,
    output logic [NUM_SRC-1:0] dirty_o
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_pend
        logic line_q, pend_q, dirty_q;
        logic rise, ack_hit, evt, touched, taken;

        assign rise    = line[i] && !line_q;
        assign ack_hit = ack_en && (ack_idx == SRC_W'(i));
        assign evt     = level[i] ? (line[i] != pend_q) : rise;
        assign touched = touch_en && (touch_idx == SRC_W'(i));
        assign taken   = take_en && (take_idx == SRC_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                line_q  <= 1'b0;
                pend_q  <= 1'b0;
                dirty_q <= 1'b0;
            end else begin
                line_q <= line[i];
                if (level[i]) begin
                    pend_q <= line[i];
                end else if (rise) begin
                    pend_q <= 1'b1;
                end else if (ack_hit) begin
                    pend_q <= 1'b0;
                end
                if (evt || touched) begin
                    dirty_q <= 1'b1;
                end else if (taken) begin
                    dirty_q <= 1'b0;
                end
            end
        end

        assign pend_o[i]  = pend_q;
        assign dirty_o[i] = dirty_q;
    end

endmodule

// File: rtl/irq_route_fsm.sv
module irq_route_fsm
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_CPU = 4,
    localparam int SRC_W  = $clog2(NUM_SRC),
    localparam int CPU_W  = $clog2(NUM_CPU)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SRC-1:0]         dirty,
    input  logic [NUM_SRC-1:0]         pend,
    input  logic [NUM_SRC-1:0]         mask,
    input  logic [NUM_SRC-1:0]         act,
    input  logic [NUM_SRC-1:0]         mode,
    input  logic [NUM_SRC*NUM_CPU-1:0] dest_flat,
    input  logic [NUM_SRC*PRIO_W-1:0]  prio_flat,
    input  logic [NUM_SRC*VEC_W-1:0]   vec_flat,
    output logic                       take_en,
    output logic [SRC_W-1:0]           take_idx,
    output logic                       act_upd,
    output logic [SRC_W-1:0]           act_idx,
    output logic                       act_val,
    output logic [NUM_CPU-1:0]         raise_o,
    output logic [NUM_CPU-1:0]         drop_o,
    output logic [SRC_W-1:0]           src_o,
    output logic [PRIO_W-1:0]          prio_o,
    output logic [VEC_W-1:0]           vec_o
);

    route_state_e       st_q, st_d;
    logic [SRC_W-1:0]   cur_q;
    logic [CPU_W-1:0]   last_q [NUM_SRC];

    logic [NUM_CPU-1:0] dest_cur, sel_cpu;
    logic [CPU_W-1:0]   last_cur, rot_idx;
    logic               rot_hit, go, now_pend, upd_last, routing;
    logic [CPU_W:0]     cw;

    // lowest-index dirty source wins the claim
    always_comb begin
        take_idx = '0;
        for (int k = NUM_SRC - 1; k >= 0; k--) begin
            if (dirty[k]) take_idx = SRC_W'(k);
        end
    end

    assign take_en = (st_q == RT_IDLE) && (|dirty);
    assign routing = (st_q == RT_ROUTE);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RT_IDLE:  if (|dirty) st_d = RT_ROUTE;
            RT_ROUTE: st_d = RT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= RT_IDLE;
            cur_q <= '0;
        end else begin
            st_q <= st_d;
            if (take_en) cur_q <= take_idx;
        end
    end

    // evaluation of the claimed source
    assign dest_cur = dest_flat[cur_q*NUM_CPU +: NUM_CPU];
    assign last_cur = last_q[cur_q];
    assign now_pend = pend[cur_q];
    assign go       = !mask[cur_q] && (now_pend || act[cur_q]);

    always_comb begin
        rot_hit = 1'b0;
        rot_idx = last_cur;
        cw      = '0;
        for (int k = 1; k < NUM_CPU; k++) begin
            cw = {1'b0, last_cur} + (CPU_W+1)'(k);
            if (cw >= (CPU_W+1)'(NUM_CPU)) cw = cw - (CPU_W+1)'(NUM_CPU);
            if (!rot_hit && dest_cur[cw[CPU_W-1:0]]) begin
                rot_hit = 1'b1;
                rot_idx = cw[CPU_W-1:0];
            end
        end
    end

    always_comb begin
        sel_cpu  = '0;
        upd_last = 1'b0;
        if (dest_cur == '0) begin
            sel_cpu = '0;
        end else if (dest_cur == (NUM_CPU'(1) << last_cur)) begin
            sel_cpu = dest_cur;
        end else if (!mode[cur_q]) begin
            sel_cpu = dest_cur;
        end else begin
            sel_cpu  = NUM_CPU'(1) << rot_idx;
            upd_last = rot_hit;
        end
    end

    assign act_upd = routing && go;
    assign act_idx = cur_q;
    assign act_val = now_pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_SRC; k++) last_q[k] <= '0;
        end else if (routing && go && upd_last) begin
            last_q[cur_q] <= rot_idx;
        end
    end

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raise_o <= '0;
            drop_o  <= '0;
            src_o   <= '0;
            prio_o  <= '0;
            vec_o   <= '0;
        end else begin
            raise_o <= '0;
            drop_o  <= '0;
            if (routing && go) begin
                raise_o <= now_pend ? sel_cpu : '0;
                drop_o  <= now_pend ? '0 : sel_cpu;
                src_o   <= cur_q;
                prio_o  <= prio_flat[cur_q*PRIO_W +: PRIO_W];
                vec_o   <= vec_flat[cur_q*VEC_W +: VEC_W];
            end
        end
    end

endmodule

// File: rtl/irq_src_router.sv
module irq_src_router
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC   = 32,
    parameter int NUM_CPU   = 4,
    parameter int INT_FIRST = 16,
    parameter int SPC_FIRST = 28,
    localparam int SRC_W    = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_line,
    input  logic               cfg_wr,
    input  logic [SRC_W-1:0]   cfg_sel,
    input  logic               cfg_field,
    input  logic [31:0]        cfg_wdata,
    output logic [31:0]        cfg_rdata,
    input  logic               ack_clr,
    input  logic [SRC_W-1:0]   ack_src,
    output logic [NUM_CPU-1:0] raise_cpu,
    output logic [NUM_CPU-1:0] drop_cpu,
    output logic [SRC_W-1:0]   out_src,
    output logic [3:0]         out_prio,
    output logic [15:0]        out_vec
);

    logic [NUM_SRC-1:0]         mask_w, act_w, mode_w, level_w, pend_w, dirty_w;
    logic [NUM_SRC*PRIO_W-1:0]  prio_w;
    logic [NUM_SRC*VEC_W-1:0]   vec_w;
    logic [NUM_SRC*NUM_CPU-1:0] dest_w;
    logic                       take_en, act_upd, act_val;
    logic [SRC_W-1:0]           take_idx, act_idx;

    irq_src_cfg #(
        .NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU),
        .INT_FIRST(INT_FIRST), .SPC_FIRST(SPC_FIRST)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_wr), .sel(cfg_sel), .sel_dest(cfg_field), .wdata(cfg_wdata),
        .rdata(cfg_rdata),
        .act_upd(act_upd), .act_idx(act_idx), .act_val(act_val),
        .ack_en(ack_clr), .ack_idx(ack_src),
        .mask_o(mask_w), .act_o(act_w), .mode_o(mode_w), .level_o(level_w),
        .prio_o(prio_w), .vec_o(vec_w), .dest_o(dest_w)
    );

    irq_src_pending #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk(clk), .rst_n(rst_n),
        .line(src_line), .level(level_w),
        .ack_en(ack_clr), .ack_idx(ack_src),
        .touch_en(cfg_wr && !cfg_field), .touch_idx(cfg_sel),
        .take_en(take_en), .take_idx(take_idx),
        .pend_o(pend_w), .dirty_o(dirty_w)
    );

    irq_route_fsm #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .dirty(dirty_w), .pend(pend_w), .mask(mask_w), .act(act_w), .mode(mode_w),
        .dest_flat(dest_w), .prio_flat(prio_w), .vec_flat(vec_w),
        .take_en(take_en), .take_idx(take_idx),
        .act_upd(act_upd), .act_idx(act_idx), .act_val(act_val),
        .raise_o(raise_cpu), .drop_o(drop_cpu),
        .src_o(out_src), .prio_o(out_prio), .vec_o(out_vec)
    );

endmodule

// File: rtl/irq_src_router_chk.sv
module irq_src_router_chk #(
    parameter int NUM_SRC = 32,
    parameter int NUM_CPU = 4,
    parameter int SRC_W   = 5
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       ack_clr,
    input logic [NUM_CPU-1:0]         raise_cpu,
    input logic [NUM_CPU-1:0]         drop_cpu,
    input logic [SRC_W-1:0]           out_src,
    input logic [NUM_SRC-1:0]         mask_w,
    input logic [NUM_SRC-1:0]         act_w,
    input logic [NUM_SRC-1:0]         mode_w,
    input logic [NUM_SRC*NUM_CPU-1:0] dest_w
);

    logic [NUM_SRC-1:0]         mask_d, mode_d;
    logic [NUM_SRC*NUM_CPU-1:0] dest_d;
    logic                       ack_d, any_out;
    logic [NUM_CPU-1:0]         dest_at, both;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_d <= '1;
            mode_d <= '0;
            dest_d <= '0;
            ack_d  <= 1'b0;
        end else begin
            mask_d <= mask_w;
            mode_d <= mode_w;
            dest_d <= dest_w;
            ack_d  <= ack_clr;
        end
    end

    assign both    = raise_cpu | drop_cpu;
    assign any_out = |both;
    assign dest_at = dest_d[out_src*NUM_CPU +: NUM_CPU];

    AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        !((|raise_cpu) && (|drop_cpu))); // R10
    AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        any_out |-> !mask_d[out_src]); // R3
    AST_WITHIN_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        any_out |-> ((both & ~dest_at) == '0)); // R7
    AST_DIST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (any_out && mode_d[out_src]) |-> ($countones(both) == 1)); // R8
    AST_RAISE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((|raise_cpu) && !ack_d) |-> act_w[out_src]); // R4
    AST_DROP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((|drop_cpu) && !ack_d) |-> !act_w[out_src]); // R4

endmodule

bind irq_src_router irq_src_router_chk #(
    .NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .SRC_W(SRC_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ack_clr(ack_clr),
    .raise_cpu(raise_cpu), .drop_cpu(drop_cpu), .out_src(out_src),
    .mask_w(mask_w), .act_w(act_w), .mode_w(mode_w), .dest_w(dest_w)
);

// File: tb/sim_irq_src_router.sv
module sim_irq_src_router;

    localparam int NS = 32;
    localparam int NC = 4;
    localparam int SW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_line = '0;
    logic          cfg_wr = 1'b0;
    logic [SW-1:0] cfg_sel = '0;
    logic          cfg_field = 1'b0;
    logic [31:0]   cfg_wdata = '0;
    logic          ack_clr = 1'b0;
    logic [SW-1:0] ack_src = '0;
    logic [31:0]   cfg_rdata;
    logic [NC-1:0] raise_cpu, drop_cpu;
    logic [SW-1:0] out_src;
    logic [3:0]    out_prio;
    logic [15:0]   out_vec;

    int checks = 0;
    int errors = 0;
    logic [31:0] rv;

    always #10 clk = ~clk;

    irq_src_router u0 (
        .clk(clk), .rst_n(rst_n), .src_line(src_line),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_field(cfg_field),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .ack_clr(ack_clr), .ack_src(ack_src),
        .raise_cpu(raise_cpu), .drop_cpu(drop_cpu),
        .out_src(out_src), .out_prio(out_prio), .out_vec(out_vec)
    );

    typedef struct packed {
        logic [4:0]  s;
        logic        md;
        logic [3:0]  dst;
        logic [3:0]  pr;
        logic [15:0] v;
        logic [3:0]  er;
        logic [3:0]  ed;
    } tv_t;

    localparam tv_t TV [6] = '{
        '{5'd1,  1'b0, 4'b0110, 4'd3,  16'h0101, 4'b0110, 4'b0110},
        '{5'd3,  1'b0, 4'b0001, 4'd7,  16'h0303, 4'b0001, 4'b0001},
        '{5'd4,  1'b1, 4'b0001, 4'd9,  16'h0404, 4'b0001, 4'b0001},
        '{5'd10, 1'b0, 4'b1111, 4'd1,  16'h0A0A, 4'b1111, 4'b1111},
        '{5'd11, 1'b0, 4'b1000, 4'd15, 16'hBEEF, 4'b1000, 4'b1000},
        '{5'd12, 1'b1, 4'b0100, 4'd5,  16'h0C0C, 4'b0100, 4'b0100}
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    function automatic logic [31:0] vp(input logic m, input logic md, input logic pol,
                                       input logic sn, input logic [3:0] pr, input logic [15:0] v);
        return {m, 1'b0, md, 5'b0, pol, sn, 2'b0, pr, v};
    endfunction

    task automatic wr(input int s, input logic f, input logic [31:0] d);
        cfg_sel = SW'(s); cfg_field = f; cfg_wdata = d; cfg_wr = 1'b1;
        step(1);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input int s, input logic f, output logic [31:0] d);
        cfg_sel = SW'(s); cfg_field = f;
        #1;
        d = cfg_rdata;
    endtask

    task automatic strobe(input string req, input logic [3:0] er, input logic [3:0] ed);
        chk(req, "raise", {28'b0, raise_cpu}, {28'b0, er});
        chk(req, "drop",  {28'b0, drop_cpu},  {28'b0, ed});
    endtask

    task automatic ack(input int s);
        ack_src = SW'(s); ack_clr = 1'b1;
        step(1);
        ack_clr = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        checks++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);

        // R2 reset state
        rd(0, 1'b0, rv);  chk("R2", "vp src0", rv, 32'h8000_0000);
        rd(16, 1'b0, rv); chk("R2", "vp internal", rv, 32'h8080_0000);
        rd(31, 1'b1, rv); chk("R2", "dest src31", rv, 32'h1);
        strobe("R2", 4'b0, 4'b0);

        // table of level sources: R4 and R7
        for (int i = 0; i < 6; i++) begin
            wr(TV[i].s, 1'b0, vp(1'b0, TV[i].md, 1'b0, 1'b1, TV[i].pr, TV[i].v));
            wr(TV[i].s, 1'b1, {28'b0, TV[i].dst});
            step(4);
            src_line[TV[i].s] = 1'b1;
            step(3);
            strobe("R7", TV[i].er, 4'b0);
            chk("R4", "src", {27'b0, out_src}, {27'b0, TV[i].s});
            chk("R4", "prio", {28'b0, out_prio}, {28'b0, TV[i].pr});
            chk("R4", "vec", {16'b0, out_vec}, {16'b0, TV[i].v});
            step(1);
            strobe("R4", 4'b0, 4'b0);
            rd(TV[i].s, 1'b0, rv); chk("R4", "act set", {31'b0, rv[30]}, 32'h1);
            src_line[TV[i].s] = 1'b0;
            step(3);
            strobe("R7", 4'b0, TV[i].ed);
            rd(TV[i].s, 1'b0, rv); chk("R4", "act clr", {31'b0, rv[30]}, 32'h0);
            step(4);
        end

        // R8 distributed rotation on source 2
        wr(2, 1'b0, vp(1'b0, 1'b1, 1'b0, 1'b1, 4'd6, 16'h0202));
        wr(2, 1'b1, 32'hB);
        step(4);
        src_line[2] = 1'b1; step(3); strobe("R8", 4'b0010, 4'b0);
        src_line[2] = 1'b0; step(3); strobe("R8", 4'b0, 4'b1000);
        src_line[2] = 1'b1; step(3); strobe("R8", 4'b0001, 4'b0);
        src_line[2] = 1'b0; step(3); strobe("R8", 4'b0, 4'b0010);
        step(2);

        // R3 masked source
        wr(6, 1'b0, vp(1'b1, 1'b0, 1'b0, 1'b1, 4'd2, 16'h0606));
        step(4);
        src_line[6] = 1'b1; step(3); strobe("R3", 4'b0, 4'b0);
        rd(6, 1'b0, rv); chk("R3", "act masked", {31'b0, rv[30]}, 32'h0);
        wr(6, 1'b0, vp(1'b0, 1'b0, 1'b0, 1'b1, 4'd2, 16'h0606));
        step(2); strobe("R3", 4'b0001, 4'b0);
        chk("R3", "src", {27'b0, out_src}, 32'd6);
        src_line[6] = 1'b0; step(3); strobe("R3", 4'b0, 4'b0001);
        step(2);

        // R6 zero destination, R1 activity preserved on write
        wr(5, 1'b1, 32'h0);
        wr(5, 1'b0, vp(1'b0, 1'b0, 1'b0, 1'b1, 4'd4, 16'h0505));
        step(4);
        src_line[5] = 1'b1; step(3); strobe("R6", 4'b0, 4'b0);
        rd(5, 1'b0, rv); chk("R6", "act no dest", {31'b0, rv[30]}, 32'h1);
        wr(5, 1'b0, vp(1'b0, 1'b0, 1'b1, 1'b1, 4'd8, 16'h5555));
        step(2); strobe("R6", 4'b0, 4'b0);
        rd(5, 1'b0, rv); chk("R1", "vp keep act", rv, 32'h40C8_5555);
        src_line[5] = 1'b0; step(3);
        rd(5, 1'b0, rv); chk("R6", "act dropped", {31'b0, rv[30]}, 32'h0);
        step(2);

        // R6 idle source write, R1 activity bit not writable
        wr(13, 1'b0, 32'h6080_1234);
        step(2); strobe("R6", 4'b0, 4'b0);
        rd(13, 1'b0, rv); chk("R1", "vp idle", rv, 32'h2080_1234);
        rd(13, 1'b1, rv); chk("R1", "dest word", rv, 32'h1);

        // R5 edge source 7
        wr(7, 1'b0, vp(1'b0, 1'b0, 1'b0, 1'b0, 4'd3, 16'h0707));
        step(4);
        src_line[7] = 1'b1; step(3); strobe("R5", 4'b0001, 4'b0);
        src_line[7] = 1'b0; step(3); strobe("R5", 4'b0, 4'b0);
        rd(7, 1'b0, rv); chk("R5", "act after fall", {31'b0, rv[30]}, 32'h1);
        ack(7); step(2); strobe("R5", 4'b0, 4'b0);
        rd(7, 1'b0, rv); chk("R5", "act after ack", {31'b0, rv[30]}, 32'h0);
        src_line[7] = 1'b1; step(3); strobe("R5", 4'b0001, 4'b0);
        ack(7); src_line[7] = 1'b0; step(4);

        // R9 internal source 16 is level and sense reads zero; R5 ack ignored
        wr(16, 1'b0, vp(1'b0, 1'b0, 1'b0, 1'b1, 4'd10, 16'h1616));
        step(2);
        rd(16, 1'b0, rv); chk("R9", "internal sense", rv, 32'h000A_1616);
        src_line[16] = 1'b1; step(3); strobe("R9", 4'b0001, 4'b0);
        ack(16); step(2);
        rd(16, 1'b0, rv); chk("R5", "ack on level", {31'b0, rv[30]}, 32'h1);
        src_line[16] = 1'b0; step(3); strobe("R9", 4'b0, 4'b0001);
        step(2);

        // R9 timer/IPI source 28 is edge, sense and polarity read zero
        wr(28, 1'b0, vp(1'b0, 1'b0, 1'b1, 1'b1, 4'd12, 16'h2828));
        step(2);
        rd(28, 1'b0, rv); chk("R9", "special bits", rv, 32'h000C_2828);
        src_line[28] = 1'b1; step(3); strobe("R9", 4'b0001, 4'b0);
        src_line[28] = 1'b0; step(3); strobe("R9", 4'b0, 4'b0);
        ack(28); step(3);

        // R10 ordering of simultaneous events
        wr(9, 1'b0, vp(1'b0, 1'b0, 1'b0, 1'b1, 4'd1, 16'h0909));
        wr(8, 1'b0, vp(1'b0, 1'b0, 1'b0, 1'b1, 4'd1, 16'h0808));
        step(4);
        src_line[9] = 1'b1; src_line[8] = 1'b1;
        step(3);
        strobe("R10", 4'b0001, 4'b0);
        chk("R10", "first src", {27'b0, out_src}, 32'd8);
        step(1); strobe("R10", 4'b0, 4'b0);
        step(1); strobe("R10", 4'b0001, 4'b0);
        chk("R10", "second src", {27'b0, out_src}, 32'd9);
        step(2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule